// File: doc/BRIEF.md
# Interlocked Event Latch Interrupt Controller

This block gathers hardware event strobes for a network media access controller into sticky latch registers, grouped one byte per group. Each group has a mask register. A group whose latched bits overlap its mask raises one bit of a read-only condition register. A separate exception register, which records blocked clearing writes, raises one more condition bit through its own mask. The condition register is masked once more by an interrupt mask, and the result drives a single interrupt line.

Software services events over a small synchronous register bus. Each read of a latch group or of the exception register saves the returned byte in one shared compare register. A later write to any latch register changes only the bits that still equal the compare value. Bits that moved after the read keep their current value. An event that arrives between the read and the clearing write is therefore kept, and the blocked attempt is flagged. Software can also load the compare register directly, so it can restore an older snapshot before it clears a different register.

Top module: `evl_intc`

## Requirements
- R1: A one on event input bit `ev_i[g*8+b]` sets bit b of latch register g (address g, for g from 0 to NUM_GROUPS-1) at the next clock edge. The bit stays one after the event input falls, until a write clears it.
- R2: If an event and a write that clears the same latch bit occur in the same cycle, the event wins and the bit stays one.
- R3: Condition register bit g (read-only, address 2G+3) is one when latch g AND mask g (address G+g) is nonzero. Bit G is one when exception AND exception mask (address 2G+1) is nonzero. All higher bits read zero, and writes to the condition register have no effect.
- R4: `irq_o` is one exactly when the condition register AND the interrupt mask (address 2G+4) is nonzero. It follows register changes in the same cycle.
- R5: A read of a latch register, or of the exception register (address 2G), loads the compare register (address 2G+2) with the returned byte. The compare register can also be written and read directly, and a read of it does not change it.
- R6: On a write to a latch register or to the exception register, bit i takes `wdata_i[i]` only when compare bit i equals the current bit i. Otherwise bit i keeps its value.
- R7: A write under R6 that is blocked on at least one bit whose written value differs from its current value sets exception bit 0 (condition-write-inhibit). The exception register is cleared by the same conditional rule.
- R8: `rdata_o` is registered. It shows the addressed register one cycle after a read strobe and holds otherwise. A cycle with both `we_i` and `re_i` performs only the write. Unmapped addresses read zero.
- R9: Reset clears all latches, masks, the compare register and the exception register, and `rdata_o` and `irq_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_i | input | NUM_GROUPS*8 | Event strobes, one byte per group |
| addr_i | input | AW | Register address |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Interrupt output |

## Verification
The bench uses the defaults: four groups, an 8-bit data path and a 5-bit address. The map is latches 0 to 3, masks 4 to 7, exception 8, exception mask 9, compare 10, condition 11 and interrupt mask 12. With four groups the exception condition lands on bit 4 while three spare condition bits stay zero. The range also reaches unmapped addresses from 13 to 31. Two latch groups can be cleared in turn with one shared compare register, so the bench exercises restoring a snapshot, an event arriving during a pending clear, and an event and a clear in the same cycle.

// File: rtl/evl_pkg.sv
package evl_pkg;
  typedef enum logic [2:0] {
    K_NONE,
    K_LATCH,
    K_MASK,
    K_EXC,
    K_EXCMASK,
    K_CMP,
    K_COND,
    K_IMASK
  } reg_kind_e;
endpackage

// File: rtl/evl_latch_reg.sv
module evl_latch_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] ev_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] cmp_i,
  output logic [W-1:0] q_o,
  output logic         blocked_o
);
  logic [W-1:0] q_q, ok, wr_val, d, hold;

  assign ok     = ~(cmp_i ^ q_q);
  assign wr_val = (ok & wdata_i) | (~ok & q_q);
  assign d      = ev_i | (wr_i ? wr_val : q_q);
  // attempted change on a bit that moved since the last read
  assign blocked_o = wr_i & |(~ok & (wdata_i ^ q_q));
  assign hold   = q_q & ~(wr_i ? (ok & ~wdata_i) : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= d;
  end

  assign q_o = q_q;

  // R1: set bits not cleared by a permitted write remain set
  a_r1_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hold) |=> ((q_q & $past(hold)) == $past(hold)));
  // R2: an event always leaves its bit set
  a_r2_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ev_i) |=> ((q_q & $past(ev_i)) == $past(ev_i)));
  // R6: mismatching bits without an event do not move on a write
  a_r6_blocked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (((q_q ^ $past(q_q)) & $past(~ok & ~ev_i)) == '0));
endmodule

// File: rtl/evl_irq_merge.sv
module evl_irq_merge #(
  parameter int NUM_GROUPS = 4,
  parameter int DW         = 8
) (
  input  logic [NUM_GROUPS*DW-1:0] lat_i,
  input  logic [NUM_GROUPS*DW-1:0] mask_i,
  input  logic [DW-1:0]            exc_i,
  input  logic [DW-1:0]            exc_mask_i,
  input  logic [DW-1:0]            imask_i,
  output logic [DW-1:0]            cond_o,
  output logic                     irq_o
);
  logic [NUM_GROUPS-1:0] grp_hit;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign grp_hit[g] = |(lat_i[g*DW +: DW] & mask_i[g*DW +: DW]);
  end

  always_comb begin
    cond_o = '0;
    cond_o[NUM_GROUPS-1:0] = grp_hit;
    cond_o[NUM_GROUPS]     = |(exc_i & exc_mask_i);
  end

  assign irq_o = |(cond_o & imask_i);
endmodule

// File: rtl/evl_regif.sv
module evl_regif
  import evl_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int DW         = 8,
  parameter int AW         = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [AW-1:0]            addr_i,
  input  logic                     we_i,
  input  logic                     re_i,
  input  logic [DW-1:0]            wdata_i,
  input  logic [NUM_GROUPS*DW-1:0] lat_i,
  input  logic [DW-1:0]            exc_i,
  input  logic [DW-1:0]            cond_i,
  output logic [NUM_GROUPS-1:0]    lat_wr_o,
  output logic                     exc_wr_o,
  output logic [NUM_GROUPS*DW-1:0] mask_o,
  output logic [DW-1:0]            exc_mask_o,
  output logic [DW-1:0]            imask_o,
  output logic [DW-1:0]            cmp_o,
  output logic [DW-1:0]            rdata_o
);
  localparam int A_MASK0   = NUM_GROUPS;
  localparam int A_EXC     = 2 * NUM_GROUPS;
  localparam int A_EXCMASK = A_EXC + 1;
  localparam int A_CMP     = A_EXC + 2;
  localparam int A_COND    = A_EXC + 3;
  localparam int A_IMASK   = A_EXC + 4;

  reg_kind_e             kind;
  int                    idx;
  logic                  rd_fire;
  logic [DW-1:0]         rd_val;
  logic [NUM_GROUPS*DW-1:0] mask_q;
  logic [DW-1:0]         exc_mask_q, imask_q, cmp_q, rdata_q;

  always_comb begin
    int a;
    a    = int'(addr_i);
    kind = K_NONE;
    idx  = 0;
    if (a < NUM_GROUPS) begin
      kind = K_LATCH;
      idx  = a;
    end else if (a < A_EXC) begin
      kind = K_MASK;
      idx  = a - A_MASK0;
    end else if (a == A_EXC)     kind = K_EXC;
    else if (a == A_EXCMASK)     kind = K_EXCMASK;
    else if (a == A_CMP)         kind = K_CMP;
    else if (a == A_COND)        kind = K_COND;
    else if (a == A_IMASK)       kind = K_IMASK;
  end

  assign rd_fire = re_i & ~we_i;

  always_comb begin
    lat_wr_o = '0;
    if (we_i && kind == K_LATCH) lat_wr_o[idx] = 1'b1;
  end
  assign exc_wr_o = we_i && kind == K_EXC;

  always_comb begin
    case (kind)
      K_LATCH:   rd_val = lat_i[idx*DW +: DW];
      K_MASK:    rd_val = mask_q[idx*DW +: DW];
      K_EXC:     rd_val = exc_i;
      K_EXCMASK: rd_val = exc_mask_q;
      K_CMP:     rd_val = cmp_q;
      K_COND:    rd_val = cond_i;
      K_IMASK:   rd_val = imask_q;
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q     <= '0;
      exc_mask_q <= '0;
      imask_q    <= '0;
      cmp_q      <= '0;
      rdata_q    <= '0;
    end else begin
      if (we_i) begin
        case (kind)
          K_MASK:    mask_q[idx*DW +: DW] <= wdata_i;
          K_EXCMASK: exc_mask_q <= wdata_i;
          K_IMASK:   imask_q <= wdata_i;
          K_CMP:     cmp_q <= wdata_i;
          default:   ;
        endcase
      end
      if (rd_fire) begin
        rdata_q <= rd_val;
        // snapshot for the read-then-clear interlock
        if (kind == K_LATCH || kind == K_EXC) cmp_q <= rd_val;
      end
    end
  end

  assign mask_o     = mask_q;
  assign exc_mask_o = exc_mask_q;
  assign imask_o    = imask_q;
  assign cmp_o      = cmp_q;
  assign rdata_o    = rdata_q;

  // R5: after a latch or exception read, compare equals returned data
  a_r5_cmp_tracks_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_fire && (kind == K_LATCH || kind == K_EXC)) |=> (cmp_q == rdata_q));
  // R8: read data holds without a read strobe
  a_r8_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_fire |=> $stable(rdata_q));
endmodule

// File: rtl/evl_intc.sv
module evl_intc #(
  parameter int NUM_GROUPS = 4,
  parameter int DW         = 8,
  parameter int AW         = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_GROUPS*DW-1:0] ev_i,
  input  logic [AW-1:0]            addr_i,
  input  logic                     we_i,
  input  logic                     re_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [DW-1:0]            rdata_o,
  output logic                     irq_o
);
  logic [NUM_GROUPS*DW-1:0] lat_q, mask;
  logic [NUM_GROUPS-1:0]    lat_wr, lat_blk;
  logic [DW-1:0]            exc_q, exc_ev, exc_mask, imask, cmp, cond;
  logic                     exc_wr, exc_blk, any_blk;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_lat
    evl_latch_reg #(.W(DW)) u_lat (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ev_i      (ev_i[g*DW +: DW]),
      .wr_i      (lat_wr[g]),
      .wdata_i   (wdata_i),
      .cmp_i     (cmp),
      .q_o       (lat_q[g*DW +: DW]),
      .blocked_o (lat_blk[g])
    );
  end

  assign any_blk = |lat_blk | exc_blk;
  assign exc_ev  = {{(DW-1){1'b0}}, any_blk};

  evl_latch_reg #(.W(DW)) u_exc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ev_i      (exc_ev),
    .wr_i      (exc_wr),
    .wdata_i   (wdata_i),
    .cmp_i     (cmp),
    .q_o       (exc_q),
    .blocked_o (exc_blk)
  );

  evl_regif #(.NUM_GROUPS(NUM_GROUPS), .DW(DW), .AW(AW)) u_regif (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .we_i       (we_i),
    .re_i       (re_i),
    .wdata_i    (wdata_i),
    .lat_i      (lat_q),
    .exc_i      (exc_q),
    .cond_i     (cond),
    .lat_wr_o   (lat_wr),
    .exc_wr_o   (exc_wr),
    .mask_o     (mask),
    .exc_mask_o (exc_mask),
    .imask_o    (imask),
    .cmp_o      (cmp),
    .rdata_o    (rdata_o)
  );

  evl_irq_merge #(.NUM_GROUPS(NUM_GROUPS), .DW(DW)) u_merge (
    .lat_i      (lat_q),
    .mask_i     (mask),
    .exc_i      (exc_q),
    .exc_mask_i (exc_mask),
    .imask_i    (imask),
    .cond_o     (cond),
    .irq_o      (irq_o)
  );

  // R7: any blocked change raises the inhibit flag
  a_r7_inhibit_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_blk |=> exc_q[0]);
  // R4: no interrupt while the interrupt mask is clear
  a_r4_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imask == '0) |-> !irq_o);
  // R3: unused condition bits stay zero
  a_r3_cond_spare: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond >> (NUM_GROUPS + 1)) == '0);
endmodule

// File: tb/evl_intc_tb.sv
`timescale 1ns/1ps
module evl_intc_tb;
  localparam int G = 4;
  localparam int NV = 13;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [G*8-1:0] ev = '0;
  logic [4:0]   addr = '0;
  logic         we = 1'b0, re = 1'b0;
  logic [7:0]   wdata = '0;
  logic [7:0]   rdata;
  logic         irq;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  evl_intc #(.NUM_GROUPS(G), .DW(8), .AW(5)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ev_i(ev), .addr_i(addr), .we_i(we),
    .re_i(re), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // {write_first, addr, wdata, expected read}
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 5'd4,  8'hFF, 8'hFF},   // R3 mask0
    {1'b1, 5'd5,  8'h08, 8'h08},   // R3 mask1
    {1'b1, 5'd6,  8'hFF, 8'hFF},   // R3 mask2
    {1'b1, 5'd7,  8'h00, 8'h00},   // R3 mask3
    {1'b1, 5'd9,  8'h01, 8'h01},   // R3 exc mask
    {1'b1, 5'd12, 8'h1F, 8'h1F},   // R4 imask
    {1'b1, 5'd10, 8'h5A, 8'h5A},   // R5 cmp write
    {1'b0, 5'd10, 8'h00, 8'h5A},   // R5 cmp read keeps value
    {1'b0, 5'd11, 8'h00, 8'h00},   // R3 cond idle
    {1'b1, 5'd11, 8'hFF, 8'h00},   // R3 cond read-only
    {1'b0, 5'd13, 8'h00, 8'h00},   // R8 unmapped
    {1'b0, 5'd31, 8'h00, 8'h00},   // R8 unmapped
    {1'b0, 5'd0,  8'h00, 8'h00}    // R1 latch idle
  };

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, string req, logic [7:0] exp);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0;
    chk(req, rdata, exp);
  endtask

  task automatic pulse(int g, logic [7:0] bits);
    @(negedge clk); ev[g*8 +: 8] = bits;
    @(negedge clk); ev = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual 0 expected 1");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 rdata reset", rdata, 8'h00);
    chk("R9 irq reset", {7'b0, irq}, 8'h00);
    rst_ni = 1'b1;
    for (int g = 0; g < G; g++) rd(5'(g), "R9 latch reset", 8'h00);
    rd(5'd8, "R9 exc reset", 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][21]) wr(VEC[i][20:16], VEC[i][15:8]);
      rd(VEC[i][20:16], "R3/R4/R5/R8 table", VEC[i][7:0]);
    end

    // R1 sticky, R3 condition, R4 interrupt
    pulse(1, 8'h08);
    chk("R4 irq on", {7'b0, irq}, 8'h01);
    rd(5'd1, "R1 sticky", 8'h08);
    rd(5'd11, "R3 cond group1", 8'h02);
    wr(5'd12, 8'h1D);
    chk("R4 irq masked", {7'b0, irq}, 8'h00);
    wr(5'd12, 8'h1F);
    chk("R4 irq unmasked", {7'b0, irq}, 8'h01);

    // R6 read-then-clear
    rd(5'd1, "R1 before clear", 8'h08);
    wr(5'd1, 8'h00);
    rd(5'd1, "R6 cleared", 8'h00);
    chk("R4 irq off", {7'b0, irq}, 8'h00);
    rd(5'd8, "R7 no inhibit", 8'h00);

    // R6/R7 event between read and write
    pulse(2, 8'h08);
    rd(5'd2, "R1 group2", 8'h08);
    pulse(2, 8'h20);
    wr(5'd2, 8'h00);
    rd(5'd2, "R6 new event kept", 8'h20);
    rd(5'd8, "R7 inhibit set", 8'h01);
    rd(5'd11, "R3 cond exc+group2", 8'h14);
    chk("R4 irq exc", {7'b0, irq}, 8'h01);

    // R5 compare restore across registers
    rd(5'd2, "R5 reread", 8'h20);
    rd(5'd8, "R5 exc read", 8'h01);
    rd(5'd10, "R5 cmp from exc", 8'h01);
    wr(5'd10, 8'h20);
    wr(5'd2, 8'h00);
    rd(5'd2, "R5 restored clear", 8'h00);
    rd(5'd8, "R7 exc still set", 8'h01);
    wr(5'd8, 8'h00);
    rd(5'd8, "R7 exc cleared", 8'h00);
    chk("R4 irq idle", {7'b0, irq}, 8'h00);

    // R2 event and clear in the same cycle
    pulse(0, 8'h01);
    rd(5'd0, "R2 setup", 8'h01);
    @(negedge clk); ev[7:0] = 8'h01; addr = 5'd0; wdata = 8'h00; we = 1'b1;
    @(negedge clk); ev = '0; we = 1'b0;
    rd(5'd0, "R2 event wins", 8'h01);
    rd(5'd8, "R2 no inhibit", 8'h00);
    rd(5'd0, "R6 reread", 8'h01);
    wr(5'd0, 8'h00);
    rd(5'd0, "R6 clear group0", 8'h00);

    // R8 write has priority over read
    @(negedge clk); addr = 5'd10; wdata = 8'h33; we = 1'b1; re = 1'b1;
    @(negedge clk); we = 1'b0; re = 1'b0;
    chk("R8 no read on write", rdata, 8'h00);
    rd(5'd10, "R8 write done", 8'h33);

    // R3 masked group
    pulse(3, 8'hFF);
    rd(5'd3, "R1 group3", 8'hFF);
    rd(5'd11, "R3 group3 masked", 8'h00);
    chk("R4 irq masked group", {7'b0, irq}, 8'h00);

    // R9 reset mid-run
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk);
    chk("R9 irq after reset", {7'b0, irq}, 8'h00);
    rst_ni = 1'b1;
    rd(5'd3, "R9 latch cleared", 8'h00);
    rd(5'd10, "R9 cmp cleared", 8'h00);
    rd(5'd4, "R9 mask cleared", 8'h00);

    summary();
    $finish;
  end
endmodule